// File: doc/BRIEF.md
# Split-Output Antilog Scaling Shifter

This block is the last stage of a fixed-point base-2 antilogarithm unit. An upstream stage approximates 2^f for the fractional part of the input and delivers it as a 17-bit mantissa with one integer bit and sixteen fraction bits, in the range [1, 2). An upstream stage also delivers the conditioned 4-bit characteristic and the sign of the original operand. This block scales the mantissa by the power of two that the characteristic encodes. It returns the result as two separate words: a 17-bit integer word, right-aligned, and a 32-bit fraction word whose LSB weighs 2^-32. Taken together, the two words give the scaled value exactly, with no bit lost to a mixed-point output word.

The characteristic indexes two 16-way candidate selections. The integer selection builds each candidate by shifting the mantissa right and then trimming it to the bits that code can produce. The fraction selection takes the bits that the integer word did not consume. It finds them by XOR against the re-aligned integer word, then places them left-aligned at the binary point. A negative operand bypasses the integer path and shifts the zero-padded mantissa right. The results are registered with one cycle of latency, and they update only on a valid input.

Top module: `antilog_split_shifter`

## Requirements
- R1: While rst_ni is low, valid_o, int_o and frac_o are all zero.
- R2: valid_o equals valid_i delayed by exactly one clock. Results appear on the clock edge after the valid input.
- R3: A cycle with valid_i low leaves int_o and frac_o unchanged, whatever sign_i, char_i and mant_i carry.
- R4: For sign_i = 1 (negative operand), int_o is zero.
- R5: For sign_i = 1 and char_i = c with c < 15, frac_o equals the 32-bit word {mant_i, 15 zero bits} shifted right by c+1.
- R6: For sign_i = 1 and char_i = 15, the shift is 15, not 16, so frac_o equals mant_i zero-extended.
- R7: For sign_i = 0 (positive operand), int_o equals floor(mant_i * 2^char_i / 2^16).
- R8: For sign_i = 0, frac_o holds the bits of mant_i * 2^char_i below the binary point. They are left-aligned so that bit 31 weighs 2^-1, and bits 15:0 are zero.
- R9: Exactness. For a positive operand, int_o*2^32 + frac_o equals mant_i*2^(char_i+16). For a negative operand, frac_o equals mant_i*2^(15-s), where s is the shift from R5/R6.
- R10: A mantissa of 79513 with characteristic 2, positive, gives int_o + frac_o*2^-32 within 0.002 of 4.853. A mantissa of 107579 with characteristic 1, negative, gives frac_o*2^-32 within 0.0005 of 0.2052.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operand valid |
| sign_i | input | 1 | Operand sign, 1 = negative |
| char_i | input | 4 | Conditioned characteristic code |
| mant_i | input | 17 | Mantissa 2^f, Q1.16 |
| valid_o | output | 1 | Result valid |
| int_o | output | 17 | Integer part of the result, right-aligned |
| frac_o | output | 32 | Fraction part of the result, LSB weight 2^-32 |

## Verification
The bench builds the block with its default parameters: a 17-bit mantissa, a 4-bit characteristic and a 32-bit fraction word. With these widths, all 16 candidates of both selections can be reached, including the irregular shift clamp on the last negative code. Every code is driven with both signs and with mantissas at the bottom, the top and in the middle of [1, 2), plus pseudo-random values. A behavioural model built on wide integer arithmetic predicts both words on every clock. Idle cycles with noisy inputs confirm that the outputs hold. The two worked operands confirm the real-valued results.

// File: rtl/antilog_shift_pkg.sv
package antilog_shift_pkg;
  // right shift for negative operands; the last code clamps instead of growing
  function automatic int unsigned neg_shift_amt(int unsigned code, int unsigned last_code);
    return (code == last_code) ? code : code + 1;
  endfunction
endpackage

// File: rtl/asp_int_chain.sv
module asp_int_chain #(
  parameter int MANT_W = 17,
  parameter int CHAR_W = 4
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [MANT_W-1:0] int_o,
  output logic [MANT_W-1:0] fbits_o
);
  localparam int NC = 2 ** CHAR_W;
  localparam int FB = MANT_W - 1;

  logic [MANT_W-1:0] cand [NC];
  logic [MANT_W-1:0] back [NC];

  for (genvar g = 0; g < NC; g++) begin : g_cand
    localparam logic [MANT_W-1:0] KEEP = MANT_W'((64'd1 << (g + 1)) - 64'd1);
    // trim to the g+1 bits that a shift by g can yield
    assign cand[g] = (mant_i >> (FB - g)) & KEEP;
    assign back[g] = cand[g] << (FB - g);
  end

  assign int_o   = cand[char_i];
  assign fbits_o = mant_i ^ back[char_i];

  always_comb begin
    assert ((fbits_o & back[char_i]) == '0)
      else $error("int/fraction split overlaps");
  end
endmodule

// File: rtl/asp_frac_chain.sv
module asp_frac_chain
  import antilog_shift_pkg::*;
#(
  parameter int MANT_W = 17,
  parameter int CHAR_W = 4,
  parameter int FRAC_W = 32
) (
  input  logic              sign_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [MANT_W-1:0] fbits_i,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int NC  = 2 ** CHAR_W;
  localparam int PAD = FRAC_W - MANT_W;

  logic [FRAC_W-1:0] pos_cand [NC];
  logic [FRAC_W-1:0] neg_cand [NC];
  logic [FRAC_W-1:0] mant_wide, fbits_wide;

  assign mant_wide  = {mant_i, {PAD{1'b0}}};
  assign fbits_wide = {fbits_i, {PAD{1'b0}}};

  for (genvar g = 0; g < NC; g++) begin : g_cand
    localparam int NSH = neg_shift_amt(g, NC - 1);
    assign pos_cand[g] = fbits_wide << (g + 1);
    assign neg_cand[g] = mant_wide >> NSH;
  end

  assign frac_o = sign_i ? neg_cand[char_i] : pos_cand[char_i];
endmodule

// File: rtl/antilog_split_shifter.sv
module antilog_split_shifter #(
  parameter int MANT_W = 17,
  parameter int CHAR_W = 4,
  parameter int FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sign_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic              valid_o,
  output logic [MANT_W-1:0] int_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int PAD = FRAC_W - MANT_W;

  logic [MANT_W-1:0] int_sel, fbits;
  logic [FRAC_W-1:0] frac_sel;

  asp_int_chain #(.MANT_W(MANT_W), .CHAR_W(CHAR_W)) u_int (
    .mant_i (mant_i),
    .char_i (char_i),
    .int_o  (int_sel),
    .fbits_o(fbits)
  );

  asp_frac_chain #(.MANT_W(MANT_W), .CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_frac (
    .sign_i (sign_i),
    .char_i (char_i),
    .mant_i (mant_i),
    .fbits_i(fbits),
    .frac_o (frac_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      int_o   <= '0;
      frac_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        int_o  <= sign_i ? '0 : int_sel;
        frac_o <= frac_sel;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(int_o) && $stable(frac_o)));
  p_neg_int_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sign_i) |=> (int_o == '0));
  p_pos_frac_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sign_i) |=> (frac_o[PAD:0] == '0));
endmodule

// File: tb/sim_antilog_split_shifter.sv
module sim_antilog_split_shifter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, sign = 1'b0;
  logic [3:0] chr = '0;
  logic [16:0] mant = '0;
  logic valid_q;
  logic [16:0] int_q;
  logic [31:0] frac_q;

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1", exp_tag = "R1";
  logic exp_valid = 1'b0;
  logic [16:0] exp_int = '0;
  logic [31:0] exp_frac = '0;
  logic [63:0] exp_total = '0;

  always #5 clk = ~clk;

  antilog_split_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sign_i(sign), .char_i(chr),
    .mant_i(mant), .valid_o(valid_q), .int_o(int_q), .frac_o(frac_q)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0; exp_int <= '0; exp_frac <= '0; exp_total <= '0;
    end else begin
      exp_valid <= valid;
      exp_tag   <= cur_tag;
      if (valid) begin
        logic [63:0] full;
        int s;
        if (!sign) begin
          full = 64'(mant) << chr;
          exp_int   <= 17'(full >> 16);
          exp_frac  <= 32'((full & 64'hFFFF) << 16);
          exp_total <= full << 16;
        end else begin
          s = (chr == 4'd15) ? 15 : int'(chr) + 1;
          full = (64'(mant) << 15) >> s;
          exp_int   <= '0;
          exp_frac  <= 32'(full);
          exp_total <= full;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({exp_tag, " valid (R2)"}, 64'(valid_q), 64'(exp_valid));
      check({exp_tag, " int"}, 64'(int_q), 64'(exp_int));
      check({exp_tag, " frac"}, 64'(frac_q), 64'(exp_frac));
      check("R9 exact", (64'(int_q) << 32) + 64'(frac_q), exp_total);
    end
  end

  task automatic apply(input logic s, input logic [3:0] c, input logic [16:0] m, input string tag);
    @(negedge clk);
    valid = 1'b1; sign = s; chr = c; mant = m; cur_tag = tag;
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [16:0] lfsr;
    real r;
    lfsr = 17'h1ACE1;
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(valid_q), 0);
    check("R1 int", 64'(int_q), 0);
    check("R1 frac", 64'(frac_q), 0);
    rst_n = 1'b1;

    for (int sg = 0; sg < 2; sg++) begin
      for (int c = 0; c < 16; c++) begin
        string t;
        if (sg == 0) t = (c % 2 == 0) ? "R7" : "R8";
        else t = (c == 15) ? "R6" : ((c % 2 == 0) ? "R5" : "R4");
        apply(sg[0], c[3:0], 17'h10000, t);
        apply(sg[0], c[3:0], 17'h1FFFF, t);
        apply(sg[0], c[3:0], 17'h1A5A5, t);
        apply(sg[0], c[3:0], 17'h13C71, t);
        for (int k = 0; k < 3; k++) begin
          lfsr = {lfsr[15:0], lfsr[16] ^ lfsr[13]};
          apply(sg[0], c[3:0], {1'b1, lfsr[15:0]}, t);
        end
      end
    end

    // R3: idle cycles with noisy inputs must not disturb the held result
    apply(1'b0, 4'd9, 17'h1F00F, "R3");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      valid = 1'b0; sign = k[0]; chr = 4'(k * 5); mant = 17'h0FFFF ^ 17'(k * 977);
      cur_tag = "R3";
    end

    // R10 worked operands
    apply(1'b0, 4'd2, 17'd79513, "R10");
    @(negedge clk);
    valid = 1'b0;
    #1;
    r = real'(int_q) + real'(frac_q) / 4294967296.0;
    n_cmp++;
    if (r < 4.851 || r > 4.855) begin
      n_bad++; $display("FAIL R10 positive: got %f expected 4.853", r);
    end
    apply(1'b1, 4'd1, 17'd107579, "R10");
    @(negedge clk);
    valid = 1'b0;
    #1;
    r = real'(frac_q) / 4294967296.0;
    n_cmp++;
    if (int_q != 0 || r < 0.2047 || r > 0.2057) begin
      n_bad++; $display("FAIL R10 negative: got %0d + %f expected 0 + 0.2052", int_q, r);
    end

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule